// File: doc/BRIEF.md
# Write-Through Register File

This block is the general-purpose register file of a five-stage pipelined processor. It holds 32 registers of 32 bits. It has two combinational read ports, used by the decode stage for the two source operands. It also has one independent write port, used by the write-back stage. Because the ports are independent, a read and a write complete in the same clock cycle without a structural conflict.

Within a cycle the write counts as happening first and the reads after it. When a read port addresses the register that is being written in the same cycle, it returns the incoming write data rather than the stale stored word. The write-back stage therefore needs no separate forwarding path into decode.

Register 0 is hard-wired to zero. Writes to it are dropped and it is never bypassed. A synchronous active-high reset clears every register. While reset is high, writes are ignored and no bypass takes place.

Top module: `rf_wtr_top`

## Requirements
- R1: After reset has been high across a rising edge and then released, every register reads as zero on both ports.
- R2: With `wr_en` high and `wr_addr` non-zero, `wr_data` is stored on the rising edge, and later reads of that address return it.
- R3: With `wr_en` low, the rising edge leaves the addressed register unchanged.
- R4: Address 0 always reads as zero on both ports, and a write to address 0 leaves it zero.
- R5: When `wr_en` is high, reset is low and `rs_addr` equals a non-zero `wr_addr`, `rs_data` equals `wr_data` in that same cycle.
- R6: The rule of R5 holds independently on `rt_addr`/`rt_data`, including when both read ports address the register being written.
- R7: With `wr_en` low, a read whose address equals `wr_addr` returns the stored value, not `wr_data`.
- R8: A same-cycle write to address 0 is never bypassed: a read of address 0 stays zero.
- R9: While a write to one register is in progress, a read of a different register returns that register's stored value.
- R10: While reset is high, a write is not stored and is not bypassed to a matching read port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| wr_en | input | 1 | Write enable for the write-back port |
| wr_addr | input | 5 | Register written on the rising edge |
| wr_data | input | 32 | Data written, also the bypass value |
| rs_addr | input | 5 | First read port address |
| rs_data | output | 32 | First read port data, combinational |
| rt_addr | input | 5 | Second read port address |
| rt_data | output | 32 | Second read port data, combinational |

## Verification
The bench goes after address collisions between the write port and each read port. It covers writes that are enabled, writes that are disabled, writes to address 0, and writes during reset. A design without the bypass would return the old word on a same-cycle hit. A design that ignores the enable in the compare would leak `wr_data` on a disabled write. A design without the zero guard would forward data into register 0. A design that lets reset slip would store or forward a write that should be dropped. Random traffic biased toward matching addresses is checked against a bench model of the array, and directed cases pin each of these situations.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_NREGS   = 32;
  localparam int unsigned RF_DW      = 32;
  localparam int unsigned RF_NRDPORT = 2;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned NREGS = rf_pkg::RF_NREGS,
  parameter int unsigned DW    = rf_pkg::RF_DW,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [DW-1:0]              wdata,
  output logic [NREGS-1:0][DW-1:0]   regs_q
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_word
      always_ff @(posedge clk) begin
        if (rst)
          regs_q[i] <= '0;
        else if (we && (waddr == AW'(i)))
          regs_q[i] <= wdata;
      end
    end
  end

  // R2: an enabled write to a non-zero register lands on the edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0 && 32'(waddr) < NREGS) |=> regs_q[$past(waddr)] == $past(wdata));

  // R3: a disabled write leaves the array unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!we && !$past(rst)) |=> $stable(regs_q));

  // R4: register 0 never holds anything but zero
  a_r4_zero_reg: assert property (@(posedge clk) disable iff (rst)
    regs_q[0] == '0);
endmodule

// File: rtl/rf_rdport.sv
module rf_rdport #(
  parameter int unsigned NREGS = rf_pkg::RF_NREGS,
  parameter int unsigned DW    = rf_pkg::RF_DW,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREGS-1:0][DW-1:0] regs,
  input  logic                     byp_en,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [AW-1:0]            raddr,
  output logic [DW-1:0]            rdata
);
  logic          hit;
  logic [DW-1:0] stored;

  always_comb begin
    if (raddr == '0 || 32'(raddr) >= NREGS)
      stored = '0;
    else
      stored = regs[raddr];
  end

  assign hit   = byp_en && (raddr == waddr) && (raddr != '0);
  assign rdata = hit ? wdata : stored;

  // R7: with the write port idle or blocked, the stored word is returned
  a_r7_no_bypass_idle: assert property (@(posedge clk) disable iff (rst)
    (!byp_en && raddr != '0 && 32'(raddr) < NREGS) |-> rdata == regs[raddr]);

  // R8: address 0 is never fed from the write port
  a_r8_zero_read: assert property (@(posedge clk) disable iff (rst)
    (raddr == '0) |-> rdata == '0);
endmodule

// File: rtl/rf_wtr_top.sv
module rf_wtr_top #(
  parameter int unsigned NREGS = rf_pkg::RF_NREGS,
  parameter int unsigned DW    = rf_pkg::RF_DW,
  localparam int unsigned AW   = $clog2(NREGS),
  localparam int unsigned NRD  = rf_pkg::RF_NRDPORT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rs_addr,
  output logic [DW-1:0] rs_data,
  input  logic [AW-1:0] rt_addr,
  output logic [DW-1:0] rt_data
);
  logic [NREGS-1:0][DW-1:0] regs;
  logic [NRD-1:0][AW-1:0]   rd_addr;
  logic [NRD-1:0][DW-1:0]   rd_data;
  logic                     wr_live;

  assign wr_live    = wr_en && !rst;
  assign rd_addr[0] = rs_addr;
  assign rd_addr[1] = rt_addr;
  assign rs_data    = rd_data[0];
  assign rt_data    = rd_data[1];

  rf_store #(.NREGS(NREGS), .DW(DW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .regs_q (regs)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_rdport #(.NREGS(NREGS), .DW(DW)) u_port (
      .clk    (clk),
      .rst    (rst),
      .regs   (regs),
      .byp_en (wr_live),
      .waddr  (wr_addr),
      .wdata  (wr_data),
      .raddr  (rd_addr[p]),
      .rdata  (rd_data[p])
    );
  end

  // R5: first port sees the word being written
  a_r5_rs_bypass: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rs_addr == wr_addr && rs_addr != '0) |-> rs_data == wr_data);

  // R6: second port sees the word being written
  a_r6_rt_bypass: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rt_addr == wr_addr && rt_addr != '0) |-> rt_data == wr_data);

  // R9: a read of another register is untouched by the write in flight
  a_r9_other_reg: assert property (@(posedge clk) disable iff (rst)
    (rs_addr != wr_addr && rs_addr != '0) |-> rs_data == regs[rs_addr]);
endmodule

// File: tb/test_rf_wtr_top.sv
`timescale 1ns/1ps
module test_rf_wtr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rs_addr = '0;
  logic [4:0]  rt_addr = '0;
  logic [31:0] rs_data, rt_data;

  logic [31:0] model [32];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rf_wtr_top i_rf_wtr_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rs_addr(rs_addr), .rs_data(rs_data), .rt_addr(rt_addr), .rt_data(rt_data)
  );

  function automatic logic [31:0] exp_rd(input logic [4:0] ra);
    if (ra == 5'd0) return 32'd0;
    if (!rst && wr_en && wr_addr == ra) return wr_data;
    return model[ra];
  endfunction

  function automatic string classify(input logic [4:0] ra, input bit port_b);
    if (rst) return "R10";
    if (ra == 5'd0) return (wr_en && wr_addr == 5'd0) ? "R8" : "R4";
    if (wr_en && wr_addr == ra) return port_b ? "R6" : "R5";
    if (wr_addr == ra) return "R7";
    if (wr_en) return "R9";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit we, input logic [4:0] wa, input logic [31:0] wd,
                      input logic [4:0] ra, input logic [4:0] rb, input string tag);
    @(negedge clk);
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd; rs_addr = ra; rt_addr = rb;
    #1;
    check(tag != "" ? tag : classify(ra, 1'b0), rs_data, exp_rd(ra));
    check(tag != "" ? tag : classify(rb, 1'b1), rt_data, exp_rd(rb));
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < 32; k++) model[k] = '0;
    end else if (we && wa != 5'd0) begin
      model[wa] = wd;
    end
  endtask

  task automatic idle_read(input logic [4:0] ra, input logic [4:0] rb, input string tag);
    step(1'b0, 1'b0, 5'd0, 32'd0, ra, rb, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h0000_5eed);
    for (int k = 0; k < 32; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    // R1: every register zero after reset
    for (int k = 0; k < 32; k += 2) idle_read(5'(k), 5'(k + 1), "R1");
    // R2: write then read back
    step(1'b0, 1'b1, 5'd5, 32'hCAFE_0005, 5'd1, 5'd2, "");
    idle_read(5'd5, 5'd5, "R2");
    // R3 and R7: disabled write, matching read returns stored word
    step(1'b0, 1'b0, 5'd5, 32'h1111_2222, 5'd5, 5'd5, "R7");
    idle_read(5'd5, 5'd3, "R3");
    // R8 and R4: write to register 0
    step(1'b0, 1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0, "R8");
    idle_read(5'd0, 5'd0, "R4");
    // R5 and R6: both ports hit the register being written
    step(1'b0, 1'b1, 5'd7, 32'hA5A5_0007, 5'd7, 5'd7, "");
    idle_read(5'd7, 5'd5, "R2");
    // R9: write elsewhere, read unaffected register
    step(1'b0, 1'b1, 5'd9, 32'h0000_0909, 5'd5, 5'd7, "R9");
    // R6 alone on the second port
    step(1'b0, 1'b1, 5'd31, 32'hFFFF_0031, 5'd9, 5'd31, "");
    // R10: write during reset is neither bypassed nor stored
    step(1'b0, 1'b1, 5'd12, 32'h0C0C_0C0C, 5'd1, 5'd1, "");
    step(1'b1, 1'b1, 5'd12, 32'h7777_7777, 5'd12, 5'd12, "R10");
    idle_read(5'd12, 5'd7, "R10");
    // random traffic biased toward collisions
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] wa, ra, rb;
      bit we;
      wa = 5'($urandom_range(0, 31));
      we = ($urandom_range(0, 3) != 0);
      ra = ($urandom_range(0, 9) < 4) ? wa : 5'($urandom_range(0, 31));
      rb = ($urandom_range(0, 9) < 4) ? wa : 5'($urandom_range(0, 31));
      step(1'b0, we, wa, $urandom, ra, rb, "");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule